// File: doc/BRIEF.md
# Multiframe Data-Link Bit Access for a 72-Frame T1 Stream

This block gives software byte-wide access to the slow data-link channel carried in the framing-bit position of a T1 stream organised as 72-frame multiframes. The receive side watches a frame number and a per-frame framing-slot strobe. It picks the data-link bits out of even frames 26 to 72, which is 24 bits per multiframe. It collects them in a shadow register and publishes all of them at once as three bytes when the multiframe completes, then raises a one-cycle receive multiframe interrupt.

The transmit side follows its own frame number and slot strobe. At the slot of frame 1 it captures three transmit bytes into a shadow register and raises a one-cycle interrupt, so software can load the next set. In the data-link slots of that multiframe it then drives the captured bits, in arrival order. While transmit is disabled the output bit idles at 1.

A routing select sends the data-link bits of frames 26 to 72 through FIFO-side ports instead of the registers, in both directions. The FIFO storage itself, and the frame alignment that produces the frame number, live outside the block.

Top module: `slc96_dl_access`

## Requirements
- R1: After reset `rx_data_o` is zero, `rx_mfb_irq_o`, `tx_mfb_irq_o` and `rx_fifo_we_o` are low, and `tx_bit_o` is 1 while `tx_en_i` is low.
- R2: A data-link slot is a slot strobe whose frame number is even and lies in 26..72. Frame f maps to bit position (f-26)/2 of a 24-bit word. Byte k of that word sits at bits 8k+7..8k, so the first received bit is bit 0 of byte 0. Strobes in odd frames, in frames below 26, or at frame numbers above 72 (including 0) carry no data-link bit.
- R3: `rx_data_o` changes only in the cycle after a frame-72 slot taken in register routing. All 24 bits change together, and the new value includes the bit received in that frame-72 slot.
- R4: `rx_mfb_irq_o` is high for exactly the one cycle after each slot strobe with frame number 72, in either routing.
- R5: With `fifo_mode_i`=1 on a receive data-link slot, `rx_fifo_we_o` is high in the next cycle and `rx_fifo_bit_o` equals the received bit. The bit is not written to the shadow, and `rx_data_o` is left unchanged.
- R6: With `tx_en_i`=1, a transmit slot strobe at frame 1 copies `tx_data_i` into the transmit shadow and makes `tx_mfb_irq_o` high for the following cycle. No copy is made and no interrupt is raised while `tx_en_i`=0.
- R7: In register routing with transmit enabled, `tx_bit_o` during a transmit data-link slot equals the shadow bit at the R2 position, in the same cycle. Changes to `tx_data_i` after the frame-1 capture have no effect until the next capture.
- R8: In FIFO routing with transmit enabled, a transmit data-link slot raises `tx_fifo_re_o` in the same cycle, and `tx_bit_o` then equals `tx_fifo_bit_i`.
- R9: With `tx_en_i`=0, `tx_bit_o` is 1 and `tx_fifo_re_o` is low.
- R10: With transmit enabled, `tx_bit_o` is 1 and `tx_fifo_re_o` is low in every cycle that is not a transmit data-link slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_mode_i | input | 1 | 1 routes data-link bits through the FIFO ports, 0 through the registers |
| rx_frame_i | input | 7 | Receive frame number within the multiframe, 1..72 |
| rx_slot_i | input | 1 | Receive framing-bit slot strobe |
| rx_bit_i | input | 1 | Received bit at the slot |
| rx_data_o | output | 24 | Received data-link bytes, byte k at bits 8k+7..8k |
| rx_mfb_irq_o | output | 1 | Receive multiframe interrupt pulse |
| rx_fifo_we_o | output | 1 | Receive FIFO write strobe |
| rx_fifo_bit_o | output | 1 | Bit for the receive FIFO |
| tx_frame_i | input | 7 | Transmit frame number within the multiframe, 1..72 |
| tx_slot_i | input | 1 | Transmit framing-bit slot strobe |
| tx_en_i | input | 1 | Data-link transmit enable |
| tx_data_i | input | 24 | Transmit data-link bytes, same layout as receive |
| tx_fifo_bit_i | input | 1 | Bit offered by the transmit FIFO |
| tx_fifo_re_o | output | 1 | Transmit FIFO read strobe |
| tx_bit_o | output | 1 | Bit for the framing slot |
| tx_mfb_irq_o | output | 1 | Transmit multiframe interrupt pulse |

## Verification
The receive results are registered. `rx_data_o`, `rx_mfb_irq_o`, `rx_fifo_we_o` and `rx_fifo_bit_o` are due one clock after the slot that causes them, and `tx_mfb_irq_o` is due one clock after the frame-1 strobe. `tx_bit_o` and `tx_fifo_re_o` answer in the same cycle as the transmit strobe, using the shadow as it stood after the previous edge. The bench changes inputs just after a falling edge, updates its model at the rising edge, and compares every output at the next falling edge. Registered results are therefore seen exactly one edge late, and the combinational transmit outputs are seen against the inputs still applied.

// File: rtl/slc96_pkg.sv
`timescale 1ns/1ps
package slc96_pkg;
  typedef enum logic {
    ROUTE_REG  = 1'b0,
    ROUTE_FIFO = 1'b1
  } route_e;

  localparam int DEF_FRAME_W   = 7;
  localparam int DEF_MF_FRAMES = 72;
  localparam int DEF_DL_FIRST  = 26;
  localparam int DEF_REG_W     = 8;
  localparam int DEF_NUM_REGS  = 3;
endpackage

// File: rtl/slc96_slot_dec.sv
`timescale 1ns/1ps
module slc96_slot_dec #(
  parameter int FRAME_W   = 7,
  parameter int MF_FRAMES = 72,
  parameter int DL_FIRST  = 26,
  parameter int DL_BITS   = 24,
  parameter int POS_W     = $clog2(DL_BITS)
) (
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               slot_i,
  output logic               dl_o,
  output logic [POS_W-1:0]   pos_o,
  output logic               first_o,
  output logic               last_o
);
  logic [FRAME_W-1:0] off;
  logic               in_rng;

  assign off    = frame_i - FRAME_W'(DL_FIRST);
  assign in_rng = !frame_i[0] && (frame_i >= FRAME_W'(DL_FIRST)) &&
                  (frame_i <= FRAME_W'(MF_FRAMES));
  assign dl_o    = slot_i && in_rng;
  assign pos_o   = POS_W'(off >> 1);
  assign first_o = slot_i && (frame_i == FRAME_W'(1));
  assign last_o  = slot_i && (frame_i == FRAME_W'(MF_FRAMES));
endmodule

// File: rtl/slc96_rx.sv
`timescale 1ns/1ps
module slc96_rx
  import slc96_pkg::*;
#(
  parameter int FRAME_W   = 7,
  parameter int MF_FRAMES = 72,
  parameter int DL_FIRST  = 26,
  parameter int DL_BITS   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  route_e             route_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               slot_i,
  input  logic               bit_i,
  output logic [DL_BITS-1:0] data_o,
  output logic               mfb_irq_o,
  output logic               fifo_we_o,
  output logic               fifo_bit_o
);
  localparam int POS_W = $clog2(DL_BITS);

  logic             dl, first, last;
  logic [POS_W-1:0] pos;
  logic [DL_BITS-1:0] sh_q, sh_d;
  logic             to_reg;

  slc96_slot_dec #(
    .FRAME_W(FRAME_W), .MF_FRAMES(MF_FRAMES), .DL_FIRST(DL_FIRST),
    .DL_BITS(DL_BITS), .POS_W(POS_W)
  ) u_dec (
    .frame_i(frame_i), .slot_i(slot_i), .dl_o(dl), .pos_o(pos),
    .first_o(first), .last_o(last)
  );

  assign to_reg = dl && (route_i == ROUTE_REG);

  always_comb begin
    sh_d = sh_q;
    for (int i = 0; i < DL_BITS; i++) begin
      if (to_reg && (pos == POS_W'(i))) sh_d[i] = bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      data_o     <= '0;
      mfb_irq_o  <= 1'b0;
      fifo_we_o  <= 1'b0;
      fifo_bit_o <= 1'b0;
    end else begin
      sh_q       <= sh_d;
      if (to_reg && last) data_o <= sh_d; // publish incl. final bit
      mfb_irq_o  <= last;
      fifo_we_o  <= dl && (route_i == ROUTE_FIFO);
      fifo_bit_o <= bit_i;
    end
  end

  // R3
  rx_data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slot_i && frame_i == FRAME_W'(MF_FRAMES) && route_i == ROUTE_REG)
    |=> $stable(data_o));
  // R4
  rx_irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mfb_irq_o |=> !mfb_irq_o);
  // R5
  rx_fifo_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dl && route_i == ROUTE_FIFO)
    |=> fifo_we_o && fifo_bit_o == $past(bit_i) && $stable(data_o));
  // R2
  rx_no_dl_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slot_i || frame_i[0]) |=> !fifo_we_o);
  logic unused_first;
  assign unused_first = first;
endmodule

// File: rtl/slc96_tx.sv
`timescale 1ns/1ps
module slc96_tx
  import slc96_pkg::*;
#(
  parameter int FRAME_W   = 7,
  parameter int MF_FRAMES = 72,
  parameter int DL_FIRST  = 26,
  parameter int DL_BITS   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  route_e             route_i,
  input  logic               en_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               slot_i,
  input  logic [DL_BITS-1:0] data_i,
  input  logic               fifo_bit_i,
  output logic               fifo_re_o,
  output logic               bit_o,
  output logic               mfb_irq_o
);
  localparam int POS_W = $clog2(DL_BITS);

  logic             dl, first, last;
  logic [POS_W-1:0] pos;
  logic [DL_BITS-1:0] sh_q;
  logic             sh_bit;

  slc96_slot_dec #(
    .FRAME_W(FRAME_W), .MF_FRAMES(MF_FRAMES), .DL_FIRST(DL_FIRST),
    .DL_BITS(DL_BITS), .POS_W(POS_W)
  ) u_dec (
    .frame_i(frame_i), .slot_i(slot_i), .dl_o(dl), .pos_o(pos),
    .first_o(first), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      mfb_irq_o <= 1'b0;
    end else begin
      if (first && en_i) sh_q <= data_i;
      mfb_irq_o <= first && en_i;
    end
  end

  always_comb begin
    sh_bit = 1'b1;
    for (int i = 0; i < DL_BITS; i++) begin
      if (pos == POS_W'(i)) sh_bit = sh_q[i];
    end
  end

  assign fifo_re_o = en_i && dl && (route_i == ROUTE_FIFO);
  assign bit_o     = !(en_i && dl) ? 1'b1 :
                     (route_i == ROUTE_FIFO) ? fifo_bit_i : sh_bit;

  // R9
  tx_disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> bit_o && !fifo_re_o);
  // R6
  tx_irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mfb_irq_o |-> $past(en_i && slot_i && frame_i == FRAME_W'(1)));
  // R8
  tx_fifo_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_re_o |-> bit_o == fifo_bit_i && route_i == ROUTE_FIFO);
  // R10
  tx_no_slot_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |-> bit_o && !fifo_re_o);
  logic unused_last;
  assign unused_last = last;
endmodule

// File: rtl/slc96_dl_access.sv
`timescale 1ns/1ps
module slc96_dl_access
  import slc96_pkg::*;
#(
  parameter int FRAME_W   = DEF_FRAME_W,
  parameter int MF_FRAMES = DEF_MF_FRAMES,
  parameter int DL_FIRST  = DEF_DL_FIRST,
  parameter int REG_W     = DEF_REG_W,
  parameter int NUM_REGS  = DEF_NUM_REGS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fifo_mode_i,
  input  logic [FRAME_W-1:0]          rx_frame_i,
  input  logic                        rx_slot_i,
  input  logic                        rx_bit_i,
  output logic [REG_W*NUM_REGS-1:0]   rx_data_o,
  output logic                        rx_mfb_irq_o,
  output logic                        rx_fifo_we_o,
  output logic                        rx_fifo_bit_o,
  input  logic [FRAME_W-1:0]          tx_frame_i,
  input  logic                        tx_slot_i,
  input  logic                        tx_en_i,
  input  logic [REG_W*NUM_REGS-1:0]   tx_data_i,
  input  logic                        tx_fifo_bit_i,
  output logic                        tx_fifo_re_o,
  output logic                        tx_bit_o,
  output logic                        tx_mfb_irq_o
);
  localparam int DL_BITS = REG_W * NUM_REGS;

  route_e route;
  assign route = fifo_mode_i ? ROUTE_FIFO : ROUTE_REG;

  slc96_rx #(
    .FRAME_W(FRAME_W), .MF_FRAMES(MF_FRAMES), .DL_FIRST(DL_FIRST), .DL_BITS(DL_BITS)
  ) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .route_i(route),
    .frame_i(rx_frame_i), .slot_i(rx_slot_i), .bit_i(rx_bit_i),
    .data_o(rx_data_o), .mfb_irq_o(rx_mfb_irq_o),
    .fifo_we_o(rx_fifo_we_o), .fifo_bit_o(rx_fifo_bit_o)
  );

  slc96_tx #(
    .FRAME_W(FRAME_W), .MF_FRAMES(MF_FRAMES), .DL_FIRST(DL_FIRST), .DL_BITS(DL_BITS)
  ) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .route_i(route), .en_i(tx_en_i),
    .frame_i(tx_frame_i), .slot_i(tx_slot_i), .data_i(tx_data_i),
    .fifo_bit_i(tx_fifo_bit_i), .fifo_re_o(tx_fifo_re_o),
    .bit_o(tx_bit_o), .mfb_irq_o(tx_mfb_irq_o)
  );
endmodule

// File: tb/slc96_dl_access_tb.sv
`timescale 1ns/1ps
module slc96_dl_access_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        fifo_mode;
  logic [6:0]  rx_frame, tx_frame;
  logic        rx_slot, rx_bit, tx_slot, tx_en, tx_fifo_bit;
  logic [23:0] tx_data;
  logic [23:0] rx_data;
  logic        rx_irq, rx_we, rx_fbit, tx_re, tx_bit, tx_irq;

  slc96_dl_access u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_mode_i(fifo_mode),
    .rx_frame_i(rx_frame), .rx_slot_i(rx_slot), .rx_bit_i(rx_bit),
    .rx_data_o(rx_data), .rx_mfb_irq_o(rx_irq),
    .rx_fifo_we_o(rx_we), .rx_fifo_bit_o(rx_fbit),
    .tx_frame_i(tx_frame), .tx_slot_i(tx_slot), .tx_en_i(tx_en),
    .tx_data_i(tx_data), .tx_fifo_bit_i(tx_fifo_bit),
    .tx_fifo_re_o(tx_re), .tx_bit_o(tx_bit), .tx_mfb_irq_o(tx_irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit        m_sh[24];
  bit        m_tsh[24];
  bit        m_rdata[24];
  bit        m_rirq, m_we, m_fbit, m_tirq;

  function automatic bit is_dl(int f, bit s);
    return s && (f % 2 == 0) && f >= 26 && f <= 72;
  endfunction

  function automatic int pack(bit a[24]);
    int v = 0;
    for (int i = 0; i < 24; i++) if (a[i]) v |= (1 << i);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 24; i++) begin m_sh[i] = 0; m_tsh[i] = 0; m_rdata[i] = 0; end
      m_rirq = 0; m_we = 0; m_fbit = 0; m_tirq = 0;
    end else begin
      m_rirq = rx_slot && rx_frame == 72;
      m_we   = is_dl(int'(rx_frame), rx_slot) && fifo_mode;
      m_fbit = rx_bit;
      if (is_dl(int'(rx_frame), rx_slot) && !fifo_mode) begin
        m_sh[(int'(rx_frame) - 26) / 2] = rx_bit;
        if (rx_frame == 72) m_rdata = m_sh;
      end
      m_tirq = tx_slot && tx_frame == 1 && tx_en;
      if (m_tirq) for (int i = 0; i < 24; i++) m_tsh[i] = tx_data[i];
    end
  end

  task automatic compare_all();
    bit tdl;
    int eb;
    string tg;
    tdl = is_dl(int'(tx_frame), tx_slot);
    chk("R2/R3 rx_data", int'(rx_data), pack(m_rdata));
    chk("R4 rx_irq", int'(rx_irq), int'(m_rirq));
    chk("R5 rx_we", int'(rx_we), int'(m_we));
    if (m_we) chk("R5 rx_fifo_bit", int'(rx_fbit), int'(m_fbit));
    chk("R6 tx_irq", int'(tx_irq), int'(m_tirq));
    if (!tx_en)                begin eb = 1; tg = "R9 tx_bit"; end
    else if (!tdl)             begin eb = 1; tg = "R10 tx_bit"; end
    else if (fifo_mode)        begin eb = int'(tx_fifo_bit); tg = "R8 tx_bit"; end
    else                       begin eb = int'(m_tsh[(int'(tx_frame) - 26) / 2]); tg = "R7 tx_bit"; end
    chk(tg, int'(tx_bit), eb);
    chk(tx_en && tdl && fifo_mode ? "R8 tx_re" : "R9/R10 tx_re",
        int'(tx_re), int'(tx_en && tdl && fifo_mode));
  endtask

  int rx_cnt = 1;
  int tx_cnt = 31;

  task automatic drive_side(ref int cnt, output logic [6:0] fr, output logic sl);
    int r = $urandom % 12;
    if (r < 4) begin
      sl = 0; fr = 7'(cnt);
    end else if (r == 4) begin // stray frame number
      sl = 1; fr = ($urandom % 2) ? 7'd0 : 7'(73 + $urandom % 55);
    end else begin
      sl = 1; fr = 7'(cnt);
      cnt = (cnt == 72) ? 1 : cnt + 1;
    end
  endtask

  initial begin
    rst_n = 0; fifo_mode = 0; rx_frame = 0; tx_frame = 0; rx_slot = 0;
    rx_bit = 0; tx_slot = 0; tx_en = 0; tx_fifo_bit = 0; tx_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rx_data", int'(rx_data), 0);
    chk("R1 rx_irq", int'(rx_irq), 0);
    chk("R1 tx_irq", int'(tx_irq), 0);
    chk("R1 rx_we", int'(rx_we), 0);
    chk("R1 tx_bit", int'(tx_bit), 1);
    rst_n = 1;
    for (int ph = 0; ph < 5; ph++) begin
      for (int c = 0; c < 420; c++) begin
        @(negedge clk);
        compare_all();
        case (ph)
          0: begin fifo_mode = 0; tx_en = 1; end
          1: begin fifo_mode = 1; tx_en = 1; end
          2: begin fifo_mode = 0; tx_en = 0; end
          3: begin fifo_mode = 0; tx_en = 1; end
          default: begin fifo_mode = 1'($urandom); tx_en = ($urandom % 8) != 0; end
        endcase
        drive_side(rx_cnt, rx_frame, rx_slot);
        drive_side(tx_cnt, tx_frame, tx_slot);
        rx_bit = 1'($urandom);
        tx_fifo_bit = 1'($urandom);
        tx_data = 24'($urandom);
      end
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule